// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This block runs the complete bulk-erase procedure for a byte-wide flash array from the host side. When started, it first drives every byte of the array to 00h. It does this by handing one address at a time to a separate byte-program sequencer and waiting for that sequencer's completion pulse. Pre-programming leaves all cells in a common state, so the later erasure is uniform.

After pre-programming, the block applies an erase pulse: two back-to-back erase command writes followed by a fixed settling delay. It then checks the array one byte at a time. For each byte it writes the erase-verify command together with the byte's address, waits a short margin delay, issues a read and compares the returned byte with FFh.

When a byte does not read back as FFh, the block keeps that address and applies another erase pulse. Verification then continues from the kept address rather than from zero. The number of erase pulses is bounded. Running out of pulses ends the run with a failure. A clean pass ends with a read-array command write. All delays are counted in clock cycles. Supply switching and the array itself lie outside the block.

Top module: `erase_seq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, busy, done, fail, wr_en, rd_req and prog_start are all 0.
- R2: A start pulse in idle raises busy in the next cycle. The block then issues one prog_start per address, 0 up to LAST_ADDR in ascending order. Each one is issued only after prog_done has answered the previous request, and no command write occurs before the last program completes.
- R3: A prog_done returned with prog_ok=0 ends the run. The next cycle has done=1 and fail=1, and no erase command is ever written.
- R4: An erase pulse is exactly two consecutive cycles with wr_en=1 and wr_data=20h, followed by ERASE_WAIT cycles with no strobe, before the verify command.
- R5: The verify of an address is a write of A0h with mem_addr set to that address, then VERIFY_WAIT cycles with no strobe, then one cycle of rd_req with the same mem_addr. Verification starts at address 0 and moves up one address per passing byte.
- R6: When the byte at LAST_ADDR reads back FFh, the next cycle writes 00h, and the cycle after that has done=1 and fail=0.
- R7: A verify read other than FFh is followed by a new erase pulse. Verification then resumes at the same address, so a run whose worst byte needs k pulses makes exactly LAST_ADDR+k reads.
- R8: At most MAX_PULSES erase pulses are applied. A mismatch after the MAX_PULSES-th pulse ends the run with done=1 and fail=1 and no further erase. A byte that clears on exactly that pulse still passes.
- R9: start is ignored while a run is in progress. done is a single-cycle pulse during which busy is 0. fail keeps its value after done until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an erase run (accepted only while idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Outcome of the last run, 1 = failure |
| wr_en | output | 1 | Command write strobe to the array |
| wr_data | output | 8 | Command byte for the write |
| mem_addr | output | ADDR_W | Address for command writes, reads and program requests |
| rd_req | output | 1 | Read request strobe |
| rd_valid | input | 1 | Read data is present this cycle |
| rd_data | input | 8 | Returned read byte |
| prog_start | output | 1 | Ask the program sequencer to write 00h at mem_addr |
| prog_done | input | 1 | Program sequencer finished the current request |
| prog_ok | input | 1 | Program sequencer outcome, valid with prog_done |

## Verification
The bench targets resumption after a mismatch, because a design that restarts at address 0 makes more reads than LAST_ADDR plus the worst byte's pulse count. It also covers the pulse cap at its exact edge. A byte needing exactly MAX_PULSES pulses must pass, and one needing a single pulse more must fail. An off-by-one cap flips one of these two outcomes. A program failure in mid-array must stop the run before any erase write, so a block that keeps going would show erase writes. Start pulses injected during a run show whether the block wrongly restarts. A restart would disturb the cycle-exact sequence of strobes and addresses that the reference model predicts.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

   localparam logic [7:0] OP_READ_ARRAY = 8'h00;
   localparam logic [7:0] OP_ERASE      = 8'h20;
   localparam logic [7:0] OP_ERASE_CHK  = 8'hA0;
   localparam logic [7:0] VAL_BLANK     = 8'hFF;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE_ISSUE,
      ST_PRE_WAIT,
      ST_ER_SETUP,
      ST_ER_GO,
      ST_ER_WAIT,
      ST_VF_SETUP,
      ST_VF_WAIT,
      ST_VF_READ,
      ST_VF_RESP,
      ST_FIN,
      ST_END
   } seq_state_e;

endpackage

// File: rtl/erase_seq_timer.sv
module erase_seq_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (run && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/erase_seq_pulse_cnt.sv
module erase_seq_pulse_cnt #(
   parameter int unsigned MAX_PULSES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_cap
);
   localparam int unsigned PW = $clog2(MAX_PULSES + 1);
   localparam logic [PW-1:0] CAP = PW'(MAX_PULSES);

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt_q <= '0;
      else if (inc && cnt_q != CAP)
         cnt_q <= cnt_q + 1'b1;
   end

   assign at_cap = (cnt_q == CAP);
endmodule

// File: rtl/erase_seq_addr.sv
module erase_seq_addr #(
   parameter int unsigned ADDR_W    = 17,
   parameter int unsigned LAST_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr,
   output logic              is_last
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         addr <= '0;
      else if (inc)
         addr <= addr + 1'b1;
   end

   assign is_last = (addr == LAST);
endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
   import erase_seq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 17,
   parameter int unsigned LAST_ADDR   = 131071,
   parameter int unsigned MAX_PULSES  = 1000,
   parameter int unsigned ERASE_WAIT  = 1000000,
   parameter int unsigned VERIFY_WAIT = 600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              wr_en,
   output logic [7:0]        wr_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              rd_req,
   input  logic              rd_valid,
   input  logic [7:0]        rd_data,
   output logic              prog_start,
   input  logic              prog_done,
   input  logic              prog_ok
);
   localparam int unsigned LONG_WAIT = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT;
   localparam int unsigned TW        = $clog2(LONG_WAIT + 1);
   localparam logic [TW-1:0] ER_LOAD = TW'(ERASE_WAIT - 1);
   localparam logic [TW-1:0] VF_LOAD = TW'(VERIFY_WAIT - 1);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
      $error("erase_seq_ctrl: ADDR_W must be 1..32");
   end
   if ((64'(LAST_ADDR) >> ADDR_W) != 0) begin : g_bad_last
      $error("erase_seq_ctrl: LAST_ADDR does not fit ADDR_W");
   end
   if (MAX_PULSES < 1) begin : g_bad_cap
      $error("erase_seq_ctrl: MAX_PULSES must be at least 1");
   end
   if (ERASE_WAIT < 1 || VERIFY_WAIT < 1) begin : g_bad_wait
      $error("erase_seq_ctrl: wait lengths must be at least 1");
   end

   seq_state_e state_q, state_d;
   logic addr_clr, addr_inc, is_last;
   logic pc_clr, pc_inc, at_cap;
   logic t_load, t_run, t_expired;
   logic [TW-1:0] t_val;
   logic fail_q, fail_set, fail_clr;
   logic [ADDR_W-1:0] addr;

   erase_seq_addr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
      .addr(addr), .is_last(is_last)
   );

   erase_seq_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_pulses (
      .clk(clk), .rst_n(rst_n), .clr(pc_clr), .inc(pc_inc), .at_cap(at_cap)
   );

   erase_seq_timer #(.CW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
      .run(t_run), .expired(t_expired)
   );

   always_comb begin
      state_d  = state_q;
      addr_clr = 1'b0;
      addr_inc = 1'b0;
      pc_clr   = 1'b0;
      pc_inc   = 1'b0;
      t_load   = 1'b0;
      t_val    = ER_LOAD;
      t_run    = 1'b0;
      fail_set = 1'b0;
      fail_clr = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               addr_clr = 1'b1;
               pc_clr   = 1'b1;
               fail_clr = 1'b1;
               state_d  = ST_PRE_ISSUE;
            end
         end
         ST_PRE_ISSUE: state_d = ST_PRE_WAIT;
         ST_PRE_WAIT: begin
            if (prog_done) begin
               if (!prog_ok) begin
                  fail_set = 1'b1;
                  state_d  = ST_END;
               end else if (is_last) begin
                  addr_clr = 1'b1;
                  state_d  = ST_ER_SETUP;
               end else begin
                  addr_inc = 1'b1;
                  state_d  = ST_PRE_ISSUE;
               end
            end
         end
         ST_ER_SETUP: state_d = ST_ER_GO;
         ST_ER_GO: begin
            pc_inc  = 1'b1;
            t_load  = 1'b1;
            t_val   = ER_LOAD;
            state_d = ST_ER_WAIT;
         end
         ST_ER_WAIT: begin
            t_run = 1'b1;
            if (t_expired) state_d = ST_VF_SETUP;
         end
         ST_VF_SETUP: begin
            t_load  = 1'b1;
            t_val   = VF_LOAD;
            state_d = ST_VF_WAIT;
         end
         ST_VF_WAIT: begin
            t_run = 1'b1;
            if (t_expired) state_d = ST_VF_READ;
         end
         ST_VF_READ: state_d = ST_VF_RESP;
         ST_VF_RESP: begin
            if (rd_valid) begin
               if (rd_data == VAL_BLANK) begin
                  if (is_last) begin
                     state_d = ST_FIN;
                  end else begin
                     addr_inc = 1'b1;
                     state_d  = ST_VF_SETUP;
                  end
               end else if (at_cap) begin
                  fail_set = 1'b1;
                  state_d  = ST_END;
               end else begin
                  state_d = ST_ER_SETUP;
               end
            end
         end
         ST_FIN:  state_d = ST_END;
         ST_END:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (fail_clr)
            fail_q <= 1'b0;
         else if (fail_set)
            fail_q <= 1'b1;
      end
   end

   always_comb begin
      wr_en   = 1'b0;
      wr_data = OP_READ_ARRAY;
      unique case (state_q)
         ST_ER_SETUP, ST_ER_GO: begin
            wr_en   = 1'b1;
            wr_data = OP_ERASE;
         end
         ST_VF_SETUP: begin
            wr_en   = 1'b1;
            wr_data = OP_ERASE_CHK;
         end
         ST_FIN: begin
            wr_en   = 1'b1;
            wr_data = OP_READ_ARRAY;
         end
         default: ;
      endcase
   end

   assign rd_req     = (state_q == ST_VF_READ);
   assign prog_start = (state_q == ST_PRE_ISSUE);
   assign mem_addr   = addr;
   assign busy       = (state_q != ST_IDLE) && (state_q != ST_END);
   assign done       = (state_q == ST_END);
   assign fail       = fail_q;
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       fail,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic       rd_req,
   input logic       prog_start
);
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, rd_req, prog_start})); // R4

   AST_ERASE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == 8'h20 && !$past(wr_en && wr_data == 8'h20))
      |=> (wr_en && wr_data == 8'h20)); // R4

   AST_READ_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !$past(wr_en)); // R5

   AST_PROG_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> busy); // R2

   AST_PASS_READCMD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fail) |-> $past(wr_en && wr_data == 8'h00)); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9

   AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(fail)); // R9
endmodule

bind erase_seq_ctrl erase_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .fail(fail), .wr_en(wr_en), .wr_data(wr_data), .rd_req(rd_req),
   .prog_start(prog_start)
);

// File: tb/test_erase_seq_ctrl.sv
module test_erase_seq_ctrl;
   localparam int AW   = 4;
   localparam int LAST = 9;
   localparam int MAXP = 4;
   localparam int EW   = 5;
   localparam int VW   = 3;

   logic clk = 1'b0;
   logic rst_n, start;
   logic busy, done, fail, wr_en, rd_req, prog_start;
   logic [7:0] wr_data;
   logic [AW-1:0] mem_addr;
   logic rd_valid = 1'b0;
   logic [7:0] rd_data = 8'h00;
   logic prog_done = 1'b0;
   logic prog_ok = 1'b0;

   always #4 clk = ~clk;

   erase_seq_ctrl #(.ADDR_W(AW), .LAST_ADDR(LAST), .MAX_PULSES(MAXP),
                    .ERASE_WAIT(EW), .VERIFY_WAIT(VW)) i_erase_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .fail(fail), .wr_en(wr_en), .wr_data(wr_data), .mem_addr(mem_addr),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
      .prog_start(prog_start), .prog_done(prog_done), .prog_ok(prog_ok)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- device and program-sequencer model ----------------
   int need [0:LAST];
   int bad_prog = -1;
   bit clr_dev = 0;
   int dev_progs = 0, dev_erw = 0, dev_reads = 0;
   int pcnt = 0, rcnt = 0, paddr = 0, raddr = 0;

   always @(posedge clk) begin
      prog_done <= 1'b0;
      rd_valid  <= 1'b0;
      if (!rst_n || clr_dev) begin
         dev_progs <= 0; dev_erw <= 0; dev_reads <= 0; pcnt <= 0; rcnt <= 0;
      end else begin
         if (prog_start) begin
            dev_progs <= dev_progs + 1;
            pcnt  <= 3;
            paddr <= int'(mem_addr);
         end else if (pcnt != 0) begin
            pcnt <= pcnt - 1;
            if (pcnt == 1) begin
               prog_done <= 1'b1;
               prog_ok   <= (paddr != bad_prog);
            end
         end
         if (wr_en && wr_data == 8'h20) dev_erw <= dev_erw + 1;
         if (rd_req) begin
            dev_reads <= dev_reads + 1;
            rcnt  <= 2;
            raddr <= int'(mem_addr);
         end else if (rcnt != 0) begin
            rcnt <= rcnt - 1;
            if (rcnt == 1) begin
               rd_valid <= 1'b1;
               rd_data  <= ((dev_erw / 2) >= need[raddr]) ? 8'hFF : 8'h5A;
            end
         end
      end
   end

   // ---------------- behavioural reference model ----------------
   string exp_tag = "R1";
   bit exp_busy = 0, exp_done = 0, exp_fail = 0;
   bit exp_wr = 0, exp_rd = 0, exp_ps = 0, exp_achk = 0;
   logic [7:0] exp_wd = 8'h00;
   int exp_addr = 0;

   task automatic show(input string tg, input bit b, input bit wr, input logic [7:0] wd,
                       input bit rd, input bit ps, input bit ac, input int ad);
      exp_tag = tg; exp_busy = b; exp_done = 0; exp_wr = wr; exp_wd = wd;
      exp_rd = rd; exp_ps = ps; exp_achk = ac; exp_addr = ad;
   endtask

   task automatic show_end(input string tg, input bit f);
      show(tg, 0, 0, 8'h00, 0, 0, 0, 0);
      exp_done = 1; exp_fail = f;
      @(posedge clk);
   endtask

   task automatic run_ref();
      bit ok = 1;
      bit need_erase = 1;
      int outcome = 0;
      int pulses = 0;
      int a = 0;
      string tg = "R4";
      exp_fail = 0;
      for (int p = 0; p <= LAST; p++) begin
         show("R2", 1, 0, 8'h00, 0, 1, 1, p);
         @(posedge clk);
         show("R2", 1, 0, 8'h00, 0, 0, 0, 0);
         do @(posedge clk); while (!prog_done);
         if (!prog_ok) begin ok = 0; break; end
      end
      if (!ok) begin
         show_end("R3", 1);
         return;
      end
      while (outcome == 0) begin
         if (need_erase) begin
            show(tg, 1, 1, 8'h20, 0, 0, 0, 0); @(posedge clk);
            show(tg, 1, 1, 8'h20, 0, 0, 0, 0); @(posedge clk);
            pulses++;
            repeat (EW) begin show(tg, 1, 0, 8'h00, 0, 0, 0, 0); @(posedge clk); end
            need_erase = 0;
         end
         show(tg, 1, 1, 8'hA0, 0, 0, 1, a); @(posedge clk);
         repeat (VW) begin show(tg, 1, 0, 8'h00, 0, 0, 0, 0); @(posedge clk); end
         show(tg, 1, 0, 8'h00, 1, 0, 1, a); @(posedge clk);
         show(tg, 1, 0, 8'h00, 0, 0, 0, 0);
         do @(posedge clk); while (!rd_valid);
         if (rd_data == 8'hFF) begin
            if (a == LAST) outcome = 1;
            else begin a++; tg = "R5"; end
         end else if (pulses == MAXP) begin
            outcome = 2;
         end else begin
            need_erase = 1; tg = "R7";
         end
      end
      if (outcome == 1) begin
         show("R6", 1, 1, 8'h00, 0, 0, 0, 0); @(posedge clk);
         show_end("R6", 0);
      end else begin
         show_end("R8", 1);
      end
   endtask

   initial begin
      forever begin
         show("R9", 0, 0, 8'h00, 0, 0, 0, 0);
         @(posedge clk);
         if (!rst_n) exp_fail = 0;
         else if (start) run_ref();
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !finished) begin
         chk(busy == exp_busy, exp_tag, "busy", busy, exp_busy);
         chk(done == exp_done, exp_tag, "done", done, exp_done);
         chk(fail == exp_fail, exp_tag, "fail", fail, exp_fail);
         chk(wr_en == exp_wr, exp_tag, "wr_en", wr_en, exp_wr);
         chk(rd_req == exp_rd, exp_tag, "rd_req", rd_req, exp_rd);
         chk(prog_start == exp_ps, exp_tag, "prog_start", prog_start, exp_ps);
         if (exp_wr) chk(wr_data == exp_wd, exp_tag, "wr_data", wr_data, exp_wd);
         if (exp_achk) chk(int'(mem_addr) == exp_addr, exp_tag, "mem_addr", mem_addr, exp_addr);
      end
   end

   // ---------------- stimulus ----------------
   task automatic set_need(input int base);
      for (int i = 0; i <= LAST; i++) need[i] = base;
   endtask

   task automatic run_case(input string tag, input int bad, input bit exp_f,
                           input int exp_pulses, input int exp_reads,
                           input int exp_progs, input bit poke);
      int n = 0;
      bad_prog = bad;
      clr_dev = 1; @(negedge clk); clr_dev = 0;
      start = 1; @(negedge clk); start = 0;
      while (!done && n < 20000) begin
         start = (poke && (n % 7 == 3));
         @(negedge clk);
         n++;
      end
      start = 0;
      chk(done == 1'b1, tag, "run reached done", done, 1);
      chk(fail == exp_f, tag, "final fail", fail, exp_f);
      chk(dev_erw / 2 == exp_pulses, tag, "erase pulses", dev_erw / 2, exp_pulses);
      chk(dev_reads == exp_reads, tag, "verify reads", dev_reads, exp_reads);
      chk(dev_progs == exp_progs, tag, "program requests", dev_progs, exp_progs);
      repeat (4) @(negedge clk);
      chk(fail == exp_f, "R9", "fail held after done", fail, exp_f);
      chk(busy == 1'b0, "R9", "busy low after done", busy, 0);
   endtask

   initial begin
      rst_n = 0; start = 0;
      set_need(1);
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && fail == 0, "R1", "status in reset", {busy, done, fail}, 0);
      chk(wr_en == 0 && rd_req == 0 && prog_start == 0, "R1", "strobes in reset",
          {wr_en, rd_req, prog_start}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && fail == 0, "R1", "status after reset", {busy, done, fail}, 0);
      chk(wr_en == 0 && rd_req == 0 && prog_start == 0, "R1", "strobes after reset",
          {wr_en, rd_req, prog_start}, 0);

      set_need(1);
      run_case("R6", -1, 0, 1, LAST + 1, LAST + 1, 0);

      set_need(1); need[3] = 2; need[7] = 3;
      run_case("R7", -1, 0, 3, LAST + 1 + 2, LAST + 1, 0);

      set_need(1); need[5] = MAXP;
      run_case("R8", -1, 0, MAXP, LAST + 1 + MAXP - 1, LAST + 1, 0);

      set_need(1); need[2] = MAXP + 1;
      run_case("R8", -1, 1, MAXP, 2 + MAXP, LAST + 1, 0);

      set_need(1);
      run_case("R3", 6, 1, 0, 0, 7, 0);

      set_need(1); need[LAST] = 2;
      run_case("R9", -1, 0, 2, LAST + 2, LAST + 1, 1);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired (R2) actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule